// File: doc/BRIEF.md
# Sampled Capture Input Glitch Filter

This block removes short glitches from one timer capture input before capture logic sees it. The raw pin first passes through a synchronizer chain. A 4-bit filter code then picks two settings: how often the synchronized level is sampled (every clock, or every 2, 4, 8, 16 or 32 clocks), and how many consecutive samples must show a new level (2 to 8) before the filtered output moves to that level. The filter delay is therefore the sample period multiplied by the required run length.

Each change of the filtered output also produces a single-cycle edge pulse, which downstream capture logic can use directly. No data stream passes through the block: the filter code and the raw pin are plain level inputs with no valid/ready handshake, and the block cannot stall. A change of the filter code restarts the sample divider and the run counter but leaves the current output level in place.

Top module: `capture_input_filter`

## Requirements
- R1: While reset is asserted (rst_n low), filt_out and edge_pulse are 0, whatever raw_in does.
- R2: With filt_code = 0 there is no filtering. A level change on raw_in that is applied before clock edge 1 appears on filt_out after edge 3: two synchronizer stages, then one output register.
- R3: Sampling divisor and run length for each code: 1→(1,2), 2→(1,4), 3→(1,8), 4→(2,6), 5→(2,8), 6→(4,6), 7→(4,8), 8→(8,6), 9→(8,8), 10→(16,5), 11→(16,6), 12→(16,8), 13→(32,5), 14→(32,6), 15→(32,8).
- R4: For a nonzero code, filt_out takes a new level only after N consecutive samples all differ from the current output. Any sample equal to the current output clears the run.
- R5: A raw pulse that spans fewer than N samples never changes filt_out and never raises edge_pulse.
- R6: For a code with divisor D and run length N, a held change on raw_in (applied before edge 1) shows on filt_out after edge L, where 3+(N−1)·D ≤ L ≤ 2+N·D. When D = 1 this gives exactly L = 2+N.
- R7: In the first clock after filt_code changes, filt_out holds its level, and the sample divider and the run counter restart from zero. A run that was in progress before the change does not count toward the new run.
- R8: edge_pulse is high for exactly one clock after each change of filt_out, rising or falling, and is low at all other times.
- R9: For a nonzero code, the internal run count stays below the run length of that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_code | input | 4 | Filter setting: sample divisor and run length |
| raw_in | input | 1 | Unsynchronized capture input |
| filt_out | output | 1 | Filtered input level |
| edge_pulse | output | 1 | One-cycle pulse on each change of filt_out |

## Verification
The bound checker tests these properties on every cycle: the edge pulse lasts one cycle and tracks every output change, the output holds in the cycle after a code change, output changes in filtered mode fall only on sample strobes, bypass mode follows the synchronized input, and the run count stays in range. Some behaviours need stimulus over many cycles and only the bench scenarios can show them. These are the end-to-end latency window of every code, the rejection of pulses that are too short and of runs that are broken, and the discarding of a partial run when the code changes.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int CODE_W  = 4;
  localparam int SHIFT_W = 3;
  localparam int RUN_W   = 4;

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;   // sample divisor = 2**shift
    logic [RUN_W-1:0]   runlen;  // consecutive samples required
  } cif_cfg_t;

  function automatic cif_cfg_t cif_decode(input logic [CODE_W-1:0] code);
    cif_cfg_t c;
    case (code)
      4'd0:    c = '{shift: 3'd0, runlen: 4'd1};
      4'd1:    c = '{shift: 3'd0, runlen: 4'd2};
      4'd2:    c = '{shift: 3'd0, runlen: 4'd4};
      4'd3:    c = '{shift: 3'd0, runlen: 4'd8};
      4'd4:    c = '{shift: 3'd1, runlen: 4'd6};
      4'd5:    c = '{shift: 3'd1, runlen: 4'd8};
      4'd6:    c = '{shift: 3'd2, runlen: 4'd6};
      4'd7:    c = '{shift: 3'd2, runlen: 4'd8};
      4'd8:    c = '{shift: 3'd3, runlen: 4'd6};
      4'd9:    c = '{shift: 3'd3, runlen: 4'd8};
      4'd10:   c = '{shift: 3'd4, runlen: 4'd5};
      4'd11:   c = '{shift: 3'd4, runlen: 4'd6};
      4'd12:   c = '{shift: 3'd4, runlen: 4'd8};
      4'd13:   c = '{shift: 3'd5, runlen: 4'd5};
      4'd14:   c = '{shift: 3'd5, runlen: 4'd6};
      default: c = '{shift: 3'd5, runlen: 4'd8};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cif_sync.sv
module cif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cif_strobe.sv
module cif_strobe #(
  parameter int DIV_W   = 5,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               strobe
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit  = (ONE << shift) - ONE;
    strobe = !restart && (div_cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_cnt <= '0;
    else if (restart || strobe) div_cnt <= '0;
    else                       div_cnt <= div_cnt + ONE;
  end
endmodule

// File: rtl/cif_run.sv
module cif_run #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             bypass,
  input  logic             strobe,
  input  logic             sample,
  input  logic [RUN_W-1:0] runlen,
  output logic             level,
  output logic             edge_pulse,
  output logic [RUN_W-1:0] run_cnt
);
  logic [RUN_W-1:0] cnt_inc;

  always_comb cnt_inc = run_cnt + {{(RUN_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level      <= 1'b0;
      edge_pulse <= 1'b0;
      run_cnt    <= '0;
    end else begin
      edge_pulse <= 1'b0;
      if (restart) begin
        run_cnt <= '0;
      end else if (bypass) begin
        run_cnt <= '0;
        if (sample != level) begin
          level      <= sample;
          edge_pulse <= 1'b1;
        end
      end else if (strobe) begin
        if (sample == level) begin
          run_cnt <= '0;
        end else if (cnt_inc == runlen) begin
          level      <= sample;
          edge_pulse <= 1'b1;
          run_cnt    <= '0;
        end else begin
          run_cnt <= cnt_inc;
        end
      end
    end
  end
endmodule

// File: rtl/capture_input_filter.sv
module capture_input_filter
  import cif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] filt_code,
  input  logic              raw_in,
  output logic              filt_out,
  output logic              edge_pulse
);
  logic              sync_in;
  logic [CODE_W-1:0] code_q;
  logic              restart;
  logic              bypass;
  logic              strobe;
  cif_cfg_t          cfg;
  logic [RUN_W-1:0]  runlen;
  logic [RUN_W-1:0]  run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= filt_code;
  end

  always_comb begin
    restart = (filt_code != code_q);
    bypass  = (filt_code == '0);
    cfg     = cif_decode(filt_code);
    runlen  = cfg.runlen;
  end

  cif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (raw_in),
    .q (sync_in)
  );

  cif_strobe #(.DIV_W(DIV_W), .SHIFT_W(SHIFT_W)) u_strobe (
    .clk (clk),
    .rst_n (rst_n),
    .restart (restart),
    .shift (cfg.shift),
    .strobe (strobe)
  );

  cif_run #(.RUN_W(RUN_W)) u_run (
    .clk (clk),
    .rst_n (rst_n),
    .restart (restart),
    .bypass (bypass),
    .strobe (strobe),
    .sample (sync_in),
    .runlen (runlen),
    .level (filt_out),
    .edge_pulse (edge_pulse),
    .run_cnt (run_cnt)
  );
endmodule

// File: rtl/cif_checker.sv
module cif_checker
  import cif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] filt_code,
  input logic              sync_in,
  input logic              restart,
  input logic              strobe,
  input logic [RUN_W-1:0]  run_cnt,
  input logic [RUN_W-1:0]  runlen,
  input logic              filt_out,
  input logic              edge_pulse
);
  // R8: pulse lasts a single clock
  a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);

  // R8: pulse present exactly when the output has just changed
  a_r8_edge_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse == (filt_out != $past(filt_out)));

  // R7: output held in the restart cycle
  a_r7_restart_hold: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> $stable(filt_out));

  // R4: filtered mode changes only on a sample strobe
  a_r4_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(filt_code) != '0) && (filt_out != $past(filt_out))) |-> $past(strobe));

  // R2: bypass mode follows the synchronized input
  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_code == '0) && !restart) |=> (filt_out == $past(sync_in)));

  // R9: run count stays below the run length
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (filt_code != '0)) |-> (run_cnt < runlen));
endmodule

bind capture_input_filter cif_checker u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .filt_code (filt_code),
  .sync_in (sync_in),
  .restart (restart),
  .strobe (strobe),
  .run_cnt (run_cnt),
  .runlen (runlen),
  .filt_out (filt_out),
  .edge_pulse (edge_pulse)
);

// File: tb/capture_input_filter_tb.sv
module capture_input_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] filt_code = 4'd0;
  logic       raw_in = 1'b0;
  logic       filt_out;
  logic       edge_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  capture_input_filter u_dut (
    .clk (clk),
    .rst_n (rst_n),
    .filt_code (filt_code),
    .raw_in (raw_in),
    .filt_out (filt_out),
    .edge_pulse (edge_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one rising edge, then sample 2 ns later
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic to_neg();
    @(negedge clk);
  endtask

  function automatic int exp_div(input int c);
    if (c <= 3) return 1;
    if (c <= 5) return 2;
    if (c <= 7) return 4;
    if (c <= 9) return 8;
    if (c <= 12) return 16;
    return 32;
  endfunction

  function automatic int exp_run(input int c);
    case (c)
      1: return 2;
      2: return 4;
      4, 6, 8, 11, 14: return 6;
      10, 13: return 5;
      default: return 8;
    endcase
  endfunction

  task automatic settle(input logic lvl);
    to_neg();
    filt_code = 4'd0;
    raw_in = lvl;
    repeat (6) tick();
    to_neg();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    raw_in = 1'b1;
    repeat (4) tick();
    chk(filt_out == 1'b0, "R1 out in reset", filt_out, 0);
    chk(edge_pulse == 1'b0, "R1 edge in reset", edge_pulse, 0);
    to_neg();
    raw_in = 1'b0;
    rst_n = 1'b1;
    settle(1'b0);
  endtask

  task automatic t_bypass();
    settle(1'b0);
    raw_in = 1'b1;
    tick(); tick();
    chk(filt_out == 1'b0, "R2 bypass early", filt_out, 0);
    tick();
    chk(filt_out == 1'b1, "R2 bypass after edge3", filt_out, 1);
    chk(edge_pulse == 1'b1, "R8 bypass pulse", edge_pulse, 1);
    tick();
    chk(edge_pulse == 1'b0, "R8 bypass pulse width", edge_pulse, 0);
    settle(1'b0);
  endtask

  // measure edges from input change to output change for one direction
  task automatic measure(input int c, input logic lvl);
    int lat = 0;
    int d = exp_div(c);
    int n = exp_run(c);
    int lo = 3 + (n - 1) * d;
    int hi = 2 + n * d;
    bit seen = 0;
    to_neg();
    raw_in = lvl;
    while (!seen && lat < 400) begin
      tick();
      lat++;
      if (filt_out == lvl) seen = 1;
      else chk(edge_pulse == 1'b0, "R8 no pulse before change", edge_pulse, 0);
    end
    chk(seen && lat >= lo && lat <= hi, $sformatf("R3 R6 latency code %0d", c), lat, hi);
    chk(edge_pulse == 1'b1, $sformatf("R8 pulse code %0d", c), edge_pulse, 1);
    tick();
    chk(edge_pulse == 1'b0, $sformatf("R8 pulse width code %0d", c), edge_pulse, 0);
  endtask

  task automatic t_sweep();
    for (int c = 1; c < 16; c++) begin
      settle(1'b0);
      filt_code = c[3:0];
      repeat (3) tick();
      measure(c, 1'b1);
      repeat (2) tick();
      measure(c, 1'b0);
    end
    settle(1'b0);
  endtask

  task automatic t_glitch();
    int pulses = 0;
    bit moved = 0;
    settle(1'b0);
    filt_code = 4'd3;
    repeat (3) tick();
    to_neg();
    raw_in = 1'b1;
    repeat (7) to_neg();
    raw_in = 1'b0;
    repeat (20) begin
      tick();
      if (filt_out) moved = 1;
      if (edge_pulse) pulses++;
    end
    chk(!moved, "R5 short pulse rejected", moved, 0);
    chk(pulses == 0, "R5 no pulse for glitch", pulses, 0);
    to_neg();
    raw_in = 1'b1;
    repeat (8) to_neg();
    raw_in = 1'b0;
    pulses = 0;
    repeat (30) begin
      tick();
      if (edge_pulse) pulses++;
    end
    chk(pulses == 2, "R4 full-length pulse passes both edges", pulses, 2);
    chk(filt_out == 1'b0, "R4 returns low", filt_out, 0);
    settle(1'b0);
  endtask

  task automatic t_broken();
    bit moved = 0;
    settle(1'b0);
    filt_code = 4'd2;
    repeat (3) tick();
    to_neg();
    raw_in = 1'b1;
    repeat (3) to_neg();
    raw_in = 1'b0;
    to_neg();
    raw_in = 1'b1;
    repeat (3) to_neg();
    raw_in = 1'b0;
    repeat (20) begin
      tick();
      if (filt_out) moved = 1;
    end
    chk(!moved, "R4 broken run rejected", moved, 0);
    settle(1'b0);
  endtask

  task automatic t_restart();
    settle(1'b0);
    filt_code = 4'd3;
    repeat (3) tick();
    to_neg();
    raw_in = 1'b1;
    repeat (5) tick();
    to_neg();
    filt_code = 4'd2;
    tick();
    chk(filt_out == 1'b0, "R7 held at restart", filt_out, 0);
    repeat (3) tick();
    chk(filt_out == 1'b0, "R7 partial run discarded", filt_out, 0);
    tick();
    chk(filt_out == 1'b1, "R7 new run from zero", filt_out, 1);
    settle(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_sweep();
    t_glitch();
    t_broken();
    t_restart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule